// File: doc/BRIEF.md
# Dual Segment Relocation and Limit Checker

This block turns logical addresses into physical ones for a small processor that has no paging. It holds two separate segments, each described by an origin register and a length register. One segment serves instruction fetch and the other serves loads and stores. Every access adds its segment origin to the logical address. The access is refused when the logical address is not strictly below the segment length.

The data side accepts the two operands of a register-plus-offset address calculation and folds in the segment origin. It uses a three-input carry-save reduction followed by a single carry-propagate add, so the relocation costs little more delay than the plain address add. The limit check always uses the logical address (register plus offset) before relocation.

The four segment registers share one configuration port. That port writes and reads only while the privilege input says supervisor. A write attempted from user mode leaves every register unchanged and raises a one-cycle refusal flag. Both translation lanes are registered, so their results appear one clock after the request.

Top module: `seg_relocator`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all outputs are zero and all four segment registers are zero, so any access made before configuration is refused (length 0).
- R2: A fetch request with `if_vld` high yields, one cycle later, `if_ok` = 1 and `if_pa` = `if_addr` + program origin, modulo 2^32.
- R3: A data request with `dt_vld` high yields, one cycle later, `dt_ok` = 1 and `dt_pa` = `dt_reg` + `dt_off` + data origin, modulo 2^32.
- R4: A request whose logical address (fetch: `if_addr`; data: `dt_reg` + `dt_off` modulo 2^32) is greater than or equal to its segment length yields, one cycle later, the lane's fault output = 1, ok = 0 and physical address = 0.
- R5: Fetch uses only the program pair and data uses only the data pair. Both lanes may be active in the same cycle, and each is checked on its own.
- R6: With `sup_mode` = 1 and `cfg_we` = 1, `cfg_wdata` goes to the register picked by `cfg_sel` (0 program origin, 1 program length, 2 data origin, 3 data length). The new value first applies to requests presented in the next cycle. A request presented in the same cycle as the write uses the old value.
- R7: With `sup_mode` = 0, a write changes no register, and `cfg_denied` is 1 in the following cycle only.
- R8: `cfg_rdata` shows the register picked by `cfg_sel` in the same cycle while `sup_mode` = 1, and reads 0 while `sup_mode` = 0.
- R9: When a lane's valid input is low, that lane's ok, fault and physical address outputs are 0 in the next cycle.
- R10: Relocation wraps modulo 2^32, and the data logical address wraps before it is compared with the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_mode | input | 1 | 1 = supervisor, 0 = user |
| if_vld | input | 1 | Fetch request valid |
| if_addr | input | 32 | Fetch logical address |
| dt_vld | input | 1 | Data request valid |
| dt_reg | input | 32 | Data address register operand |
| dt_off | input | 32 | Data address immediate offset |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_sel | input | 2 | Register select (0..3, see R6) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of selected register |
| cfg_denied | output | 1 | User-mode write refused |
| if_ok | output | 1 | Fetch translated and inside segment |
| if_fault | output | 1 | Fetch outside segment |
| if_pa | output | 32 | Fetch physical address |
| dt_ok | output | 1 | Data translated and inside segment |
| dt_fault | output | 1 | Data outside segment |
| dt_pa | output | 32 | Data physical address |

## Verification
Translation results and the refusal flag come one cycle after the request or write. Configuration read data comes in the same cycle. The driver applies each stimulus on a falling edge and pushes the expected lane outputs and refusal flag into a queue. The monitor pops one item just after the next rising edge, which is the first point where the registered outputs hold that request's result. Read data is compared in the driver right after it applies a select, before any edge. The expected values come from the driver's own copy of the four registers, and a write updates that copy only after the same-cycle expectation is formed, which also covers the old-value rule of R6.

// File: rtl/seg_reloc_pkg.sv
package seg_reloc_pkg;

  localparam int unsigned AW = 32;
  localparam int unsigned SELW = 2;

  typedef logic [AW-1:0] addr_t;

  // selection codes for the configuration port
  typedef enum logic [SELW-1:0] {
    SEL_PROG_ORG = 2'd0,
    SEL_PROG_LEN = 2'd1,
    SEL_DATA_ORG = 2'd2,
    SEL_DATA_LEN = 2'd3
  } seg_sel_e;

  // three-operand carry-save reduction then one carry-propagate add
  function automatic addr_t csa_sum3(input addr_t a, input addr_t b, input addr_t c);
    addr_t s;
    addr_t cy;
    s  = a ^ b ^ c;
    cy = (a & b) | (a & c) | (b & c);
    return s + {cy[AW-2:0], 1'b0};
  endfunction

  // plain two-operand relocation
  function automatic addr_t reloc2(input addr_t la, input addr_t org);
    return la + org;
  endfunction

  // limit test on the logical address
  function automatic logic inside_seg(input addr_t la, input addr_t len);
    return la < len;
  endfunction

endpackage

// File: rtl/seg_pair_regs.sv
module seg_pair_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_org,
  input  logic         we_len,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] org_q,
  output logic [W-1:0] len_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      org_q <= '0;
      len_q <= '0;
    end else begin
      if (we_org) org_q <= wdata;
      if (we_len) len_q <= wdata;
    end
  end

endmodule

// File: rtl/seg_xlate_lane.sv
module seg_xlate_lane
  import seg_reloc_pkg::*;
#(
  parameter bit USE_CSA = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_vld,
  input  addr_t opa,
  input  addr_t opb,
  input  addr_t org,
  input  addr_t len,
  output logic  hit_c,
  output logic  viol_c,
  output logic  ok_q,
  output logic  fault_q,
  output addr_t pa_q
);

  addr_t la_c;
  addr_t pa_c;
  logic  in_c;

  assign la_c = opa + opb;
  assign in_c = inside_seg(la_c, len);

  generate
    if (USE_CSA) begin : g_csa
      assign pa_c = csa_sum3(opa, opb, org);
    end else begin : g_add
      assign pa_c = reloc2(la_c, org);
    end
  endgenerate

  assign hit_c  = req_vld & in_c;
  assign viol_c = req_vld & ~in_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok_q    <= 1'b0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      ok_q    <= hit_c;
      fault_q <= viol_c;
      pa_q    <= hit_c ? pa_c : '0;
    end
  end

endmodule

// File: rtl/seg_relocator.sv
module seg_relocator
  import seg_reloc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sup_mode,
  input  logic        if_vld,
  input  logic [31:0] if_addr,
  input  logic        dt_vld,
  input  logic [31:0] dt_reg,
  input  logic [31:0] dt_off,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_denied,
  output logic        if_ok,
  output logic        if_fault,
  output logic [31:0] if_pa,
  output logic        dt_ok,
  output logic        dt_fault,
  output logic [31:0] dt_pa
);

  localparam int unsigned NPAIR = 2;

  logic  wr_grant;
  logic  wr_refuse;
  addr_t org_r [NPAIR];
  addr_t len_r [NPAIR];
  addr_t prog_org, prog_len, data_org, data_len;
  logic  if_hit, if_viol, dt_hit, dt_viol;

  assign wr_grant  = cfg_we & sup_mode;
  assign wr_refuse = cfg_we & ~sup_mode;

  // pair 0 = program, pair 1 = data; cfg_sel[1] picks the pair, cfg_sel[0] the field
  generate
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      seg_pair_regs #(.W(AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_org (wr_grant & (cfg_sel[1] == p[0]) & ~cfg_sel[0]),
        .we_len (wr_grant & (cfg_sel[1] == p[0]) &  cfg_sel[0]),
        .wdata  (cfg_wdata),
        .org_q  (org_r[p]),
        .len_q  (len_r[p])
      );
    end
  endgenerate

  assign prog_org = org_r[0];
  assign prog_len = len_r[0];
  assign data_org = org_r[1];
  assign data_len = len_r[1];

  always_comb begin
    cfg_rdata = '0;
    if (sup_mode) begin
      unique case (seg_sel_e'(cfg_sel))
        SEL_PROG_ORG: cfg_rdata = prog_org;
        SEL_PROG_LEN: cfg_rdata = prog_len;
        SEL_DATA_ORG: cfg_rdata = data_org;
        SEL_DATA_LEN: cfg_rdata = data_len;
        default:      cfg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_denied <= 1'b0;
    else        cfg_denied <= wr_refuse;
  end

  seg_xlate_lane #(.USE_CSA(1'b0)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_vld (if_vld),
    .opa     (if_addr),
    .opb     ('0),
    .org     (prog_org),
    .len     (prog_len),
    .hit_c   (if_hit),
    .viol_c  (if_viol),
    .ok_q    (if_ok),
    .fault_q (if_fault),
    .pa_q    (if_pa)
  );

  seg_xlate_lane #(.USE_CSA(1'b1)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_vld (dt_vld),
    .opa     (dt_reg),
    .opb     (dt_off),
    .org     (data_org),
    .len     (data_len),
    .hit_c   (dt_hit),
    .viol_c  (dt_viol),
    .ok_q    (dt_ok),
    .fault_q (dt_fault),
    .pa_q    (dt_pa)
  );

endmodule

// File: rtl/seg_relocator_chk.sv
module seg_relocator_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sup_mode,
  input logic        if_vld,
  input logic [31:0] if_addr,
  input logic        dt_vld,
  input logic [31:0] dt_reg,
  input logic [31:0] dt_off,
  input logic        cfg_we,
  input logic [1:0]  cfg_sel,
  input logic [31:0] cfg_wdata,
  input logic        cfg_denied,
  input logic        if_ok,
  input logic        if_fault,
  input logic [31:0] if_pa,
  input logic        dt_ok,
  input logic        dt_fault,
  input logic [31:0] dt_pa,
  input logic [31:0] prog_org,
  input logic [31:0] prog_len,
  input logic [31:0] data_org,
  input logic [31:0] data_len
);

  // R2
  fetch_reloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_ok |-> if_pa == $past(if_addr + prog_org));

  // R3
  data_reloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dt_ok |-> dt_pa == $past(dt_reg + dt_off + data_org));

  // R4
  fetch_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_fault |-> ($past(if_addr >= prog_len) && !if_ok && if_pa == 32'd0));

  // R4
  data_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dt_fault |-> ($past(32'(dt_reg + dt_off) >= data_len) && !dt_ok && dt_pa == 32'd0));

  // R9
  fetch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !if_vld |=> (!if_ok && !if_fault));

  // R9
  data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dt_vld |=> (!dt_ok && !dt_fault));

  // R7
  user_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !sup_mode) |=> ($stable(prog_org) && $stable(prog_len) &&
                               $stable(data_org) && $stable(data_len) && cfg_denied));

  // R6
  sup_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && sup_mode && cfg_sel == 2'd0) |=> prog_org == $past(cfg_wdata));

  // R7
  denied_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_denied |-> $past(cfg_we && !sup_mode));

endmodule

bind seg_relocator seg_relocator_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sup_mode   (sup_mode),
  .if_vld     (if_vld),
  .if_addr    (if_addr),
  .dt_vld     (dt_vld),
  .dt_reg     (dt_reg),
  .dt_off     (dt_off),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .cfg_wdata  (cfg_wdata),
  .cfg_denied (cfg_denied),
  .if_ok      (if_ok),
  .if_fault   (if_fault),
  .if_pa      (if_pa),
  .dt_ok      (dt_ok),
  .dt_fault   (dt_fault),
  .dt_pa      (dt_pa),
  .prog_org   (prog_org),
  .prog_len   (prog_len),
  .data_org   (data_org),
  .data_len   (data_len)
);

// File: tb/seg_relocator_bench.sv
`timescale 1ns/1ps
module seg_relocator_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sup_mode = 1'b0;
  logic        if_vld = 1'b0;
  logic [31:0] if_addr = '0;
  logic        dt_vld = 1'b0;
  logic [31:0] dt_reg = '0;
  logic [31:0] dt_off = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_denied;
  logic        if_ok, if_fault, dt_ok, dt_fault;
  logic [31:0] if_pa, dt_pa;

  always #2 clk = ~clk;

  seg_relocator u_seg_relocator (
    .clk(clk), .rst_n(rst_n), .sup_mode(sup_mode),
    .if_vld(if_vld), .if_addr(if_addr),
    .dt_vld(dt_vld), .dt_reg(dt_reg), .dt_off(dt_off),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_denied(cfg_denied),
    .if_ok(if_ok), .if_fault(if_fault), .if_pa(if_pa),
    .dt_ok(dt_ok), .dt_fault(dt_fault), .dt_pa(dt_pa)
  );

  typedef struct {
    logic        f_ok, f_flt;
    logic [31:0] f_pa;
    logic        d_ok, d_flt;
    logic [31:0] d_pa;
    logic        den;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  logic [31:0] m_reg [4];
  bit run_mon = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request cycle: inputs on a falling edge, expectation queued
  task automatic drive(input string tag, input logic sup,
                       input logic fv, input logic [31:0] fa,
                       input logic dv, input logic [31:0] rs, input logic [31:0] off,
                       input logic we, input logic [1:0] sel, input logic [31:0] wd);
    exp_t e;
    logic [31:0] la;
    @(negedge clk);
    sup_mode = sup; if_vld = fv; if_addr = fa;
    dt_vld = dv; dt_reg = rs; dt_off = off;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    #0.5;
    chk({tag, " R8 rdata"}, cfg_rdata, sup ? m_reg[sel] : 32'd0);
    e.tag = tag;
    e.f_ok = fv && (fa < m_reg[1]);
    e.f_flt = fv && !(fa < m_reg[1]);
    e.f_pa = e.f_ok ? fa + m_reg[0] : 32'd0;
    la = rs + off;
    e.d_ok = dv && (la < m_reg[3]);
    e.d_flt = dv && !(la < m_reg[3]);
    e.d_pa = e.d_ok ? la + m_reg[2] : 32'd0;
    e.den = we && !sup;
    q.push_back(e);
    if (we && sup) m_reg[sel] = wd;
  endtask

  task automatic wr(input string tag, input logic [1:0] sel, input logic [31:0] wd);
    drive(tag, 1'b1, 1'b0, 0, 1'b0, 0, 0, 1'b1, sel, wd);
  endtask

  // monitor: registered results are due just after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #0.5;
      if (run_mon && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " if_ok"},    {31'd0, if_ok},    {31'd0, e.f_ok});
        chk({e.tag, " if_fault"}, {31'd0, if_fault}, {31'd0, e.f_flt});
        chk({e.tag, " if_pa"},    if_pa,             e.f_pa);
        chk({e.tag, " dt_ok"},    {31'd0, dt_ok},    {31'd0, e.d_ok});
        chk({e.tag, " dt_fault"}, {31'd0, dt_fault}, {31'd0, e.d_flt});
        chk({e.tag, " dt_pa"},    dt_pa,             e.d_pa);
        chk({e.tag, " R7 denied"}, {31'd0, cfg_denied}, {31'd0, e.den});
      end
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    if_vld = 1'b1; dt_vld = 1'b1; cfg_we = 1'b1; sup_mode = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #0.5;
    // R1 outputs held at zero in reset
    chk("R1 reset if_ok", {31'd0, if_ok}, 32'd0);
    chk("R1 reset dt_fault", {31'd0, dt_fault}, 32'd0);
    chk("R1 reset denied", {31'd0, cfg_denied}, 32'd0);
    @(negedge clk);
    if_vld = 1'b0; dt_vld = 1'b0; cfg_we = 1'b0;
    rst_n = 1'b1;
    #0.5;
    // R1 registers cleared, visible through readback
    for (int s = 0; s < 4; s++) begin
      cfg_sel = 2'(s);
      #0.1;
      chk("R1 reset register", cfg_rdata, 32'd0);
    end
    run_mon = 1'b1;
    // R1 unconfigured length 0 refuses everything
    drive("R1 unconfigured", 1'b1, 1'b1, 32'h0, 1'b1, 32'h0, 32'h0, 1'b0, 0, 0);
    // R6 supervisor configuration
    wr("R6 prog org", 2'd0, 32'h0000_1000);
    wr("R6 prog len", 2'd1, 32'h0000_0400);
    wr("R6 data org", 2'd2, 32'h8000_0000);
    wr("R6 data len", 2'd3, 32'h0000_0100);
    // R2 fetch relocation
    drive("R2 fetch", 1'b0, 1'b1, 32'h10, 1'b0, 0, 0, 1'b0, 0, 0);
    drive("R4 last inside", 1'b0, 1'b1, 32'h3FF, 1'b0, 0, 0, 1'b0, 1, 0);
    drive("R4 at limit", 1'b0, 1'b1, 32'h400, 1'b0, 0, 0, 1'b0, 2, 0);
    // R3 data relocation via register plus offset
    drive("R3 data", 1'b1, 1'b0, 0, 1'b1, 32'h20, 32'h8, 1'b0, 3, 0);
    drive("R3 negative offset", 1'b1, 1'b0, 0, 1'b1, 32'h50, 32'hFFFF_FFF0, 1'b0, 2, 0);
    drive("R4 data at limit", 1'b1, 1'b0, 0, 1'b1, 32'hF0, 32'h10, 1'b0, 0, 0);
    // R5 both lanes, each against its own pair
    drive("R5 both lanes", 1'b0, 1'b1, 32'h200, 1'b1, 32'h200, 32'h0, 1'b0, 0, 0);
    drive("R5 both inside", 1'b1, 1'b1, 32'h50, 1'b1, 32'h50, 32'h0, 1'b0, 1, 0);
    // R9 idle lanes
    drive("R9 idle", 1'b1, 1'b0, 32'h10, 1'b0, 32'h10, 32'h0, 1'b0, 0, 0);
    // R7 user write refused, then old origin still applies
    drive("R7 user write", 1'b0, 1'b0, 0, 1'b0, 0, 0, 1'b1, 0, 32'h5555_0000);
    drive("R7 after refused", 1'b1, 1'b1, 32'h20, 1'b0, 0, 0, 1'b0, 0, 0);
    // R6 write in same cycle as fetch uses old origin, next uses new
    drive("R6 same cycle", 1'b1, 1'b1, 32'h30, 1'b0, 0, 0, 1'b1, 0, 32'h0002_0000);
    drive("R6 next cycle", 1'b1, 1'b1, 32'h30, 1'b0, 0, 0, 1'b0, 0, 0);
    // R10 wrapping
    wr("R10 prog org", 2'd0, 32'hFFFF_FF00);
    drive("R10 fetch wrap", 1'b0, 1'b1, 32'h200, 1'b0, 0, 0, 1'b0, 0, 0);
    drive("R10 data la wrap", 1'b0, 1'b0, 0, 1'b1, 32'hFFFF_FFF0, 32'h20, 1'b0, 0, 0);
    wr("R10 data org", 2'd2, 32'hFFFF_FFF8);
    drive("R10 data pa wrap", 1'b1, 1'b0, 0, 1'b1, 32'h40, 32'h8, 1'b0, 2, 0);
    // mixed traffic near the limits, R2 R3 R4 R6 R7 R8
    for (int k = 0; k < 60; k++) begin
      logic we_k;
      we_k = ($urandom_range(0, 7) == 0);
      drive("mixed R4", 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 32'($urandom_range(0, 32'h500)),
            1'($urandom_range(0, 1)), 32'($urandom_range(0, 32'h180)), 32'($urandom_range(0, 32'h40)),
            we_k, 2'($urandom_range(0, 3)), 32'($urandom_range(32'h80, 32'h600)));
    end
    drive("drain", 1'b0, 1'b0, 0, 1'b0, 0, 0, 1'b0, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("queue drained", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule